// File: doc/BRIEF.md
# Progressive Clock Ramp-Up Switcher

This block lives in the PLL clock domain. It softens the load step that occurs when the system moves from a slow reference onto a fast PLL. It does not hand the full PLL rate to downstream logic at once. Instead it produces a clock-enable that climbs through a fixed staircase of rates: one eighth, then one quarter, then one half, and finally every PLL cycle. Each of the first three rates is held for a fixed number of PLL cycles.

The select input may come from another clock domain. It is first synchronised into the PLL domain, and its rising edge starts the ramp. While the select stays high the enable keeps running at full rate. When the select drops, the block falls back to idle. A later rising edge starts the ramp again from the slowest rate.

Downstream logic gates its registers with `clk_en`. It can read the `running` flag and the 2-bit `stage` code to see how far the ramp has progressed. Glitch-free switching between the two clock sources is done elsewhere.

Top module: `clk_ramp_switcher`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `clk_en` and `running` are 0 and `stage` is 0.
- R2: `sel_in` passes through a two-flop synchroniser. If `sel_in` rises between two clock edges, `running` becomes 1 after the third following rising edge, and not earlier.
- R3: During the first 8 running cycles, `stage` is 0 (divide by 8) and `clk_en` is high only on the 8th of those cycles.
- R4: During the next 16 running cycles, `stage` is 1 (divide by 4) and `clk_en` is high on every 4th cycle, counted from the start of the stage.
- R5: During the next 32 running cycles, `stage` is 2 (divide by 2) and `clk_en` is high on every 2nd cycle, counted from the start of the stage.
- R6: From running cycle 56 onward, and for as long as the select stays high, `stage` is 3 (divide by 1) and `clk_en` is high on every cycle.
- R7: `stage` changes only directly after a cycle in which `clk_en` was high, so no divided period is ever cut short.
- R8: If `sel_in` falls between two clock edges, `running` and `clk_en` go to 0 and `stage` goes to 0 after the third following rising edge. Until then the ramp continues unchanged.
- R9: A later rising edge of the select restarts the sequence at `stage` 0. This holds whether the earlier ramp was aborted part-way through or had reached full rate.
- R10: While running, `stage` only ever stays the same or increases by exactly 1. The code values are 0 for /8, 1 for /4, 2 for /2 and 3 for /1.
- R11: `clk_en` is never high while `running` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PLL output clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_in | input | 1 | Select input that requests the PLL; may be asynchronous |
| clk_en | output | 1 | Divided clock-enable, one cycle wide per divided period |
| running | output | 1 | High while a ramp is in progress or at full rate |
| stage | output | 2 | Current division stage: 0=/8, 1=/4, 2=/2, 3=/1 |

## Verification
The assertions assume that `sel_in` is held stable for at least three PLL cycles between changes. A shorter pulse may be lost in the synchroniser or may start only a fragment of a ramp, and the exact timing of such a fragment is not checked. The stimulus always changes `sel_in` on a falling clock edge, and it holds each level for at least three cycles. The high phase is swept over every length from 1 to 70 running cycles, plus one long run. This aborts the ramp at every position in every stage and restarts it each time from idle.

// File: rtl/ramp_pkg.sv
package ramp_pkg;

    // Division stage codes, in ramp order.
    typedef enum logic [1:0] {
        STG_D8 = 2'd0,
        STG_D4 = 2'd1,
        STG_D2 = 2'd2,
        STG_D1 = 2'd3
    } stage_e;

    // Width of the phase counter inside one divided period (largest divisor is 8).
    localparam int unsigned PHASE_W = 3;

    // Control state carried between the sequencer and the outputs.
    typedef struct packed {
        logic   running;
        stage_e stage;
    } ramp_ctl_t;

    localparam ramp_ctl_t CTL_IDLE = '{running: 1'b0, stage: STG_D8};

    // Last phase index of a divided period for the given stage.
    function automatic logic [PHASE_W-1:0] period_last(input stage_e s);
        case (s)
            STG_D8:  return 3'd7;
            STG_D4:  return 3'd3;
            STG_D2:  return 3'd1;
            default: return 3'd0;
        endcase
    endfunction

    // Next stage in the staircase; the last stage holds.
    function automatic stage_e next_stage(input stage_e s);
        case (s)
            STG_D8:  return STG_D4;
            STG_D4:  return STG_D2;
            default: return STG_D1;
        endcase
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/ramp_sel_sync.sv
module ramp_sel_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_async,
    output logic sel_lvl,
    output logic sel_rise
);

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   sel_prev_q;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= sel_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) sel_prev_q <= 1'b0;
        else     sel_prev_q <= chain_q[SYNC_STAGES-1];
    end

    assign sel_lvl  = chain_q[SYNC_STAGES-1];
    assign sel_rise = chain_q[SYNC_STAGES-1] & ~sel_prev_q;

endmodule

// File: rtl/ramp_phase_div.sv
module ramp_phase_div
    import ramp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ramp_ctl_t ctl,
    output logic      period_end
);

    logic [PHASE_W-1:0] phase_q;
    logic [PHASE_W-1:0] last_idx;

    always_comb begin
        last_idx   = period_last(ctl.stage);
        period_end = ctl.running && (phase_q == last_idx);
    end

    // The phase wraps at the end of every period. Stage changes happen only there,
    // so a new divisor always starts from phase 0.
    always_ff @(posedge clk) begin
        if (rst || !ctl.running) begin
            phase_q <= '0;
        end else if (phase_q == last_idx) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/ramp_sequencer.sv
module ramp_sequencer
    import ramp_pkg::*;
#(
    parameter int unsigned DWELL_D8 = 8,
    parameter int unsigned DWELL_D4 = 16,
    parameter int unsigned DWELL_D2 = 32
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sel_lvl,
    input  logic      sel_rise,
    input  logic      period_end,
    output ramp_ctl_t ctl
);

    localparam int unsigned DWELL_MAX = max3(DWELL_D8, DWELL_D4, DWELL_D2);
    localparam int unsigned DW_W      = (DWELL_MAX > 1) ? $clog2(DWELL_MAX) : 1;

    localparam logic [DW_W-1:0] LIM_D8 = DW_W'(DWELL_D8 - 1);
    localparam logic [DW_W-1:0] LIM_D4 = DW_W'(DWELL_D4 - 1);
    localparam logic [DW_W-1:0] LIM_D2 = DW_W'(DWELL_D2 - 1);

    ramp_ctl_t       ctl_q, ctl_d;
    logic [DW_W-1:0] dwell_q, dwell_d;
    logic [DW_W-1:0] dwell_lim;
    logic            dwell_done;

    always_comb begin
        case (ctl_q.stage)
            STG_D8:  dwell_lim = LIM_D8;
            STG_D4:  dwell_lim = LIM_D4;
            default: dwell_lim = LIM_D2;
        endcase
        dwell_done = (dwell_q == dwell_lim);
    end

    always_comb begin
        ctl_d   = ctl_q;
        dwell_d = dwell_q;
        if (!sel_lvl) begin
            ctl_d   = CTL_IDLE;
            dwell_d = '0;
        end else if (!ctl_q.running) begin
            if (sel_rise) begin
                ctl_d.running = 1'b1;
                ctl_d.stage   = STG_D8;
                dwell_d       = '0;
            end
        end else if (ctl_q.stage != STG_D1) begin
            if (dwell_done && period_end) begin
                ctl_d.stage = next_stage(ctl_q.stage);
                dwell_d     = '0;
            end else if (!dwell_done) begin
                dwell_d = dwell_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= CTL_IDLE;
            dwell_q <= '0;
        end else begin
            ctl_q   <= ctl_d;
            dwell_q <= dwell_d;
        end
    end

    assign ctl = ctl_q;

endmodule

// File: rtl/clk_ramp_switcher.sv
module clk_ramp_switcher
    import ramp_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DWELL_D8    = 8,
    parameter int unsigned DWELL_D4    = 16,
    parameter int unsigned DWELL_D2    = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sel_in,
    output logic       clk_en,
    output logic       running,
    output logic [1:0] stage
);

    logic      sel_lvl;
    logic      sel_rise;
    logic      period_end;
    ramp_ctl_t ctl;

    ramp_sel_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .sel_async(sel_in),
        .sel_lvl  (sel_lvl),
        .sel_rise (sel_rise)
    );

    ramp_sequencer #(
        .DWELL_D8(DWELL_D8),
        .DWELL_D4(DWELL_D4),
        .DWELL_D2(DWELL_D2)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .sel_lvl   (sel_lvl),
        .sel_rise  (sel_rise),
        .period_end(period_end),
        .ctl       (ctl)
    );

    ramp_phase_div u_div (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .period_end(period_end)
    );

    assign clk_en  = period_end;
    assign running = ctl.running;
    assign stage   = ctl.stage;

endmodule

// File: rtl/clk_ramp_checker.sv
module clk_ramp_checker (
    input logic       clk,
    input logic       rst,
    input logic       clk_en,
    input logic       running,
    input logic [1:0] stage
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !running |-> !clk_en) else $error("idle enable"); // R11

    AST_IDLE_STAGE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !running |-> (stage == 2'd0)) else $error("idle stage"); // R8

    AST_START_AT_D8: assert property (@(posedge clk) disable iff (rst)
        $rose(running) |-> (stage == 2'd0)) else $error("bad start stage"); // R9

    AST_STAGE_STEP: assert property (@(posedge clk) disable iff (rst)
        (running && $past(running)) |->
            ((stage == $past(stage)) || (stage == $past(stage) + 2'd1)))
        else $error("stage jump"); // R10

    AST_STEP_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        (running && $past(running) && (stage != $past(stage))) |-> $past(clk_en))
        else $error("stage change mid-period"); // R7

    AST_FULL_RATE: assert property (@(posedge clk) disable iff (rst)
        (running && stage == 2'd3) |-> clk_en) else $error("full rate gap"); // R6

endmodule

bind clk_ramp_switcher clk_ramp_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .clk_en (clk_en),
    .running(running),
    .stage  (stage)
);

// File: tb/tb_clk_ramp_switcher.sv
module tb_clk_ramp_switcher;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_in = 1'b0;
    logic       clk_en;
    logic       running;
    logic [1:0] stage;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    clk_ramp_switcher dut (
        .clk    (clk),
        .rst    (rst),
        .sel_in (sel_in),
        .clk_en (clk_en),
        .running(running),
        .stage  (stage)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected stage after t running cycles: 8 at /8, 16 at /4, 32 at /2, then /1.
    function automatic int exp_stage(input int t);
        if (t < 8)  return 0;
        if (t < 24) return 1;
        if (t < 56) return 2;
        return 3;
    endfunction

    function automatic int exp_en(input int t);
        int base, div;
        case (exp_stage(t))
            0: begin base = 0;  div = 8; end
            1: begin base = 8;  div = 4; end
            2: begin base = 24; div = 2; end
            default: begin base = 56; div = 1; end
        endcase
        return (((t - base + 1) % div) == 0) ? 1 : 0;
    endfunction

    function automatic string req_of(input int t);
        case (exp_stage(t))
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    // Hold select high for len running cycles, then drop it and check the return to idle.
    task automatic ramp(input int len);
        sel_in = 1'b1;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk("R2 early start", int'(running), 0);
        end
        for (int t = 0; t < len + 2; t++) begin
            @(negedge clk);
            chk({req_of(t), " running"}, int'(running), 1);
            chk({req_of(t), " stage"}, int'(stage), exp_stage(t));
            chk({req_of(t), " clk_en"}, int'(clk_en), exp_en(t));
            if (t == len - 1) sel_in = 1'b0;
        end
        @(negedge clk);
        chk("R8 running", int'(running), 0);
        chk("R8 stage", int'(stage), 0);
        chk("R8 clk_en", int'(clk_en), 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R11 idle clk_en", int'(clk_en), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset clk_en", int'(clk_en), 0);
        chk("R1 reset running", int'(running), 0);
        chk("R1 reset stage", int'(stage), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset running", int'(running), 0);
        chk("R1 after reset clk_en", int'(clk_en), 0);
        // Sweep abort points across every stage; each restart must begin at /8 (R9).
        for (int len = 1; len <= 70; len++) begin
            ramp(len);
        end
        ramp(200);
        ramp(9);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule